// File: doc/BRIEF.md
# Two-Bank GPIO Controller with Edge Events

This block drives and samples a set of general-purpose pins through a small byte-wide register port. The pins are divided into two banks at a configurable pin index: a core bank that holds the lower pin numbers, and a resume bank that holds the rest. Pins in the resume bank are numbered again from zero inside that bank. Both banks have the same register set. Each pin has six configuration or status bits: an enable, a direction, an output level, a rising-edge arm, a falling-edge arm and an event mask. It also has a sticky trigger flag.

Pad inputs pass through a two-flop synchronizer. Edges are found by comparing the synchronized value with its previous sample. When an armed edge appears on an enabled pin, the pin's trigger flag latches. Software clears the flag by writing a one to it. All flags that are unmasked, in both banks, are ORed onto one level-sensitive event line. That line stays high until the last of them is cleared or masked.

Top module: `gpio_twobank`

## Requirements
- R1: The 6-bit address selects the bank with bit 5 (0 = core, 1 = resume), the register with bits 4:2 (0 enable, 1 direction, 2 level, 3 rising arm, 4 falling arm, 5 event mask, 6 reserved, 7 trigger flags), and the byte with bits 1:0. A pin's local number L is held in byte L/8 at bit L%8.
- R2: Pins numbered below SPLIT_PIN belong to the core bank and keep their number. Pins numbered SPLIT_PIN or above belong to the resume bank with local number (pin − SPLIT_PIN).
- R3: A direction bit of 1 makes the pin an input and a 0 makes it an output. pad_oe is high only for pins that are enabled outputs. pad_out carries each pin's level bit.
- R4: When a pin is an input, writes to its level bit are ignored, and a read of the bit returns the synchronized pad value, two clock edges after the pad changes. When a pin is an output, the written value is stored and read back.
- R5: The rising and falling arms are independent. A pin with both arms set triggers on either edge.
- R6: A trigger flag latches when an armed edge occurs. It holds until a one is written to it. A new edge in the same cycle as the clear wins.
- R7: event_o is high exactly while some trigger flag whose event-mask bit is 1 is set, in either bank. Clearing a mask bit does not clear the flag.
- R8: A pin whose enable bit is 0 never drives pad_oe and never sets its trigger flag.
- R9: After reset, core pins 0–6 and resume pins 0–2 are enabled. All pins are inputs. Arms, masks, levels and flags are 0, and event_o is low.
- R10: The reserved register and any bit that has no pin behind it read as 0, and writes to them have no effect.
- R11: A pad edge that arrives before clock edge 1 shows in the trigger flag, and on event_o, after clock edge 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| addr | input | 6 | Byte address (bank, register, byte) |
| wr_en | input | 1 | Write strobe for the addressed byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed byte, combinational |
| pad_in | input | NUM_PINS | Pad input values |
| pad_out | output | NUM_PINS | Output level per pin |
| pad_oe | output | NUM_PINS | Output enable per pin |
| event_o | output | 1 | Combined level event |

## Verification
A write takes effect at the clock edge that samples it, so its result is read back through rdata in the same low clock phase that follows. After a pad changes, a level read of an input pin follows it at the second clock edge. The trigger flag and event_o follow at the third edge. The bench drives inputs 2 ns after each rising edge and checks at the falling edge. A behavioural per-pin model steps once per rising edge and is compared with rdata, pad_oe, pad_out and event_o at every falling edge. Directed checks look at the exact edges counted above.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W   = 6;
    localparam int BANK_BIT = 5;

    typedef enum logic [2:0] {
        REG_EN   = 3'd0,
        REG_DIR  = 3'd1,
        REG_LVL  = 3'd2,
        REG_RISE = 3'd3,
        REG_FALL = 3'd4,
        REG_EVT  = 3'd5,
        REG_RSVD = 3'd6,
        REG_STS  = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int          PINS   = 8,
    parameter logic [31:0] EN_RST = 32'h0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  reg_sel_e        reg_sel,
    input  logic [1:0]      byte_sel,
    input  logic [7:0]      wdata,
    input  logic [PINS-1:0] pad_sync,
    output logic [7:0]      rdata,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_oe,
    output logic            pend,
    output logic [PINS-1:0] en_q,
    output logic [PINS-1:0] dir_q,
    output logic [PINS-1:0] sts_q,
    output logic [PINS-1:0] evt_q
);
    logic [PINS-1:0] lvl_q, rise_q, fall_q, prev_q;
    logic [PINS-1:0] hit, wbit, clr, set;
    logic [PINS-1:0] rvec;
    logic [31:0]     rwide;

    for (genvar i = 0; i < PINS; i++) begin : g_lane
        assign hit[i]  = (byte_sel == 2'(i / 8));
        assign wbit[i] = wdata[i % 8];
    end

    assign set = en_q & ((rise_q & pad_sync & ~prev_q) |
                         (fall_q & ~pad_sync & prev_q));
    assign clr = (wr_en && reg_sel == REG_STS) ? (hit & wbit) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= EN_RST[PINS-1:0];
            dir_q  <= '1;
            lvl_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
            evt_q  <= '0;
            sts_q  <= '0;
            prev_q <= '0;
        end else begin
            prev_q <= pad_sync;
            sts_q  <= (sts_q & ~clr) | set;
            if (wr_en) begin
                unique case (reg_sel)
                    REG_EN:   en_q   <= (en_q & ~hit) | (wbit & hit);
                    REG_DIR:  dir_q  <= (dir_q & ~hit) | (wbit & hit);
                    REG_LVL:  lvl_q  <= (lvl_q & ~(hit & ~dir_q)) | (wbit & hit & ~dir_q);
                    REG_RISE: rise_q <= (rise_q & ~hit) | (wbit & hit);
                    REG_FALL: fall_q <= (fall_q & ~hit) | (wbit & hit);
                    REG_EVT:  evt_q  <= (evt_q & ~hit) | (wbit & hit);
                    REG_RSVD, REG_STS: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (reg_sel)
            REG_EN:   rvec = en_q;
            REG_DIR:  rvec = dir_q;
            REG_LVL:  rvec = (dir_q & pad_sync) | (~dir_q & lvl_q);
            REG_RISE: rvec = rise_q;
            REG_FALL: rvec = fall_q;
            REG_EVT:  rvec = evt_q;
            REG_STS:  rvec = sts_q;
            REG_RSVD: rvec = '0;
        endcase
        rwide = 32'(rvec);
        rdata = rwide[8*byte_sel +: 8];
    end

    assign pad_out = lvl_q;
    assign pad_oe  = en_q & ~dir_q;
    assign pend    = |(sts_q & evt_q);
endmodule

// File: rtl/gpio_twobank.sv
module gpio_twobank
    import gpio_pkg::*;
#(
    parameter int          NUM_PINS      = 14,
    parameter int          SPLIT_PIN     = 10,
    parameter logic [31:0] CORE_EN_RST   = 32'h0000_007F,
    parameter logic [31:0] RESUME_EN_RST = 32'h0000_0007
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic [7:0]          wdata,
    output logic [7:0]          rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                event_o
);
    localparam int CORE_PINS = SPLIT_PIN;
    localparam int RES_PINS  = NUM_PINS - SPLIT_PIN;

    logic [NUM_PINS-1:0] pad_sync;
    logic [NUM_PINS-1:0] en_all, dir_all, sts_all, evt_all;
    logic [7:0]          rd_core, rd_res;
    logic                pend_core, pend_res;
    logic                sel_res;
    reg_sel_e            reg_sel;

    assign sel_res = addr[BANK_BIT];
    assign reg_sel = reg_sel_e'(addr[4:2]);

    gpio_sync #(.W(NUM_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
    );

    gpio_bank #(.PINS(CORE_PINS), .EN_RST(CORE_EN_RST)) u_core (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en && !sel_res),
        .reg_sel(reg_sel), .byte_sel(addr[1:0]), .wdata(wdata),
        .pad_sync(pad_sync[CORE_PINS-1:0]), .rdata(rd_core),
        .pad_out(pad_out[CORE_PINS-1:0]), .pad_oe(pad_oe[CORE_PINS-1:0]),
        .pend(pend_core), .en_q(en_all[CORE_PINS-1:0]),
        .dir_q(dir_all[CORE_PINS-1:0]), .sts_q(sts_all[CORE_PINS-1:0]),
        .evt_q(evt_all[CORE_PINS-1:0])
    );

    gpio_bank #(.PINS(RES_PINS), .EN_RST(RESUME_EN_RST)) u_resume (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en && sel_res),
        .reg_sel(reg_sel), .byte_sel(addr[1:0]), .wdata(wdata),
        .pad_sync(pad_sync[NUM_PINS-1:SPLIT_PIN]), .rdata(rd_res),
        .pad_out(pad_out[NUM_PINS-1:SPLIT_PIN]), .pad_oe(pad_oe[NUM_PINS-1:SPLIT_PIN]),
        .pend(pend_res), .en_q(en_all[NUM_PINS-1:SPLIT_PIN]),
        .dir_q(dir_all[NUM_PINS-1:SPLIT_PIN]), .sts_q(sts_all[NUM_PINS-1:SPLIT_PIN]),
        .evt_q(evt_all[NUM_PINS-1:SPLIT_PIN])
    );

    assign rdata   = sel_res ? rd_res : rd_core;
    assign event_o = pend_core | pend_res;
endmodule

// File: rtl/gpio_twobank_chk.sv
module gpio_twobank_chk #(
    parameter int N = 14
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic         event_o,
    input logic [N-1:0] pad_oe,
    input logic [N-1:0] pad_out,
    input logic [N-1:0] en_all,
    input logic [N-1:0] dir_all,
    input logic [N-1:0] sts_all,
    input logic [N-1:0] evt_all
);
    assert_oe_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & dir_all) == '0);

    assert_oe_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~en_all) == '0);

    assert_level_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pad_out));

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((sts_all & $past(sts_all)) == $past(sts_all)));

    assert_no_flag_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts_all & ~$past(sts_all) & ~$past(en_all)) == '0));

    assert_event_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |-> ((sts_all & evt_all) != '0));
endmodule

bind gpio_twobank gpio_twobank_chk #(.N(NUM_PINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .event_o(event_o),
    .pad_oe(pad_oe), .pad_out(pad_out), .en_all(en_all), .dir_all(dir_all),
    .sts_all(sts_all), .evt_all(evt_all)
);

// File: tb/gpio_twobank_tb.sv
module gpio_twobank_tb;
    localparam int NP = 14;
    localparam int SP = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [5:0]    addr = '0;
    logic          wr_en = 1'b0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe;
    logic          event_o;

    int checks = 0;
    int errors = 0;

    // behavioural per-pin model
    logic [NP-1:0] m_en, m_dir, m_lvl, m_re, m_fe, m_ev, m_st, m_s1, m_s2, m_pv;

    always #5 clk = ~clk;

    gpio_twobank u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .event_o(event_o)
    );

    function automatic int loc_of(int p);
        return (p >= SP) ? p - SP : p;
    endfunction

    function automatic bit pin_hit(int p, logic [5:0] a);
        return (a[5] == (p >= SP)) && (int'(a[1:0]) == loc_of(p) / 8);
    endfunction

    function automatic logic [7:0] m_read(logic [5:0] a);
        logic [7:0] r = '0;
        for (int p = 0; p < NP; p++) begin
            if (pin_hit(p, a)) begin
                case (a[4:2])
                    3'd0: r[loc_of(p) % 8] = m_en[p];
                    3'd1: r[loc_of(p) % 8] = m_dir[p];
                    3'd2: r[loc_of(p) % 8] = m_dir[p] ? m_s2[p] : m_lvl[p];
                    3'd3: r[loc_of(p) % 8] = m_re[p];
                    3'd4: r[loc_of(p) % 8] = m_fe[p];
                    3'd5: r[loc_of(p) % 8] = m_ev[p];
                    3'd7: r[loc_of(p) % 8] = m_st[p];
                    default: ;
                endcase
            end
        end
        return r;
    endfunction

    function automatic string tag_of(logic [5:0] a);
        if (a[5]) return "R2";
        case (a[4:2])
            3'd0: return "R1";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3, 3'd4: return "R5";
            3'd5: return "R7";
            3'd6: return "R10";
            default: return "R6";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = '0; m_en[6:0] = '1; m_en[SP+2:SP] = '1;
            m_dir = '1; m_lvl = '0; m_re = '0; m_fe = '0; m_ev = '0;
            m_st = '0; m_s1 = '0; m_s2 = '0; m_pv = '0;
        end else begin
            logic [NP-1:0] set;
            for (int p = 0; p < NP; p++)
                set[p] = m_en[p] && ((m_re[p] && m_s2[p] && !m_pv[p]) ||
                                     (m_fe[p] && !m_s2[p] && m_pv[p]));
            if (wr_en) begin
                for (int p = 0; p < NP; p++) begin
                    if (pin_hit(p, addr)) begin
                        logic b;
                        b = wdata[loc_of(p) % 8];
                        case (addr[4:2])
                            3'd0: m_en[p] = b;
                            3'd1: m_dir[p] = b;
                            3'd2: if (!m_dir[p]) m_lvl[p] = b;
                            3'd3: m_re[p] = b;
                            3'd4: m_fe[p] = b;
                            3'd5: m_ev[p] = b;
                            3'd7: if (b) m_st[p] = 1'b0;
                            default: ;
                        endcase
                    end
                end
            end
            m_st = m_st | set;
            m_pv = m_s2; m_s2 = m_s1; m_s1 = pad_in;
        end
    end

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check(rdata == m_read(addr), tag_of(addr), 32'(rdata), 32'(m_read(addr)));
            check(pad_oe == (m_en & ~m_dir), "R8", 32'(pad_oe), 32'(m_en & ~m_dir));
            check(pad_out == m_lvl, "R3", 32'(pad_out), 32'(m_lvl));
            check(event_o == |(m_st & m_ev), "R7", 32'(event_o), 32'(|(m_st & m_ev)));
        end
    end

    task automatic wr(logic [5:0] a, logic [7:0] d);
        @(posedge clk); #2; addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #2; wr_en = 1'b0;
    endtask

    task automatic rd_expect(logic [5:0] a, logic [7:0] exp, string tag);
        @(posedge clk); #2; addr = a;
        @(negedge clk);
        check(rdata == exp, tag, 32'(rdata), 32'(exp));
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #2000000;
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] lfsr = 32'hACE1_2468;
        repeat (3) @(posedge clk);
        #2; rst_n = 1'b1;
        // R9 reset state
        rd_expect(6'h00, 8'h7F, "R9");
        rd_expect(6'h01, 8'h00, "R9");
        rd_expect(6'h20, 8'h07, "R9");
        rd_expect(6'h05, 8'h03, "R9");
        rd_expect(6'h24, 8'h0F, "R9");
        rd_expect(6'h3C, 8'h00, "R9");
        check(event_o == 1'b0, "R9", 32'(event_o), 32'h0);
        // R1 / R2 enable pins 8,9 (core byte 1) and 13 (resume bit 3)
        wr(6'h01, 8'h03);
        wr(6'h20, 8'h0F);
        rd_expect(6'h01, 8'h03, "R1");
        rd_expect(6'h20, 8'h0F, "R2");
        // R10 reserved register and absent bits
        wr(6'h18, 8'hFF);
        rd_expect(6'h18, 8'h00, "R10");
        wr(6'h22, 8'hFF);
        rd_expect(6'h22, 8'h00, "R10");
        // R4 level write ignored on input, then stored once output
        wr(6'h08, 8'h0F);
        rd_expect(6'h08, 8'h00, "R4");
        wr(6'h04, 8'hF0);
        wr(6'h08, 8'h05);
        rd_expect(6'h08, 8'h05, "R4");
        check(pad_oe[3:0] == 4'hF, "R3", 32'(pad_oe), 32'hF);
        wr(6'h04, 8'hFF);
        // R5 arms: pin0 rise, pin1 fall, pin2 both; R8 pin7 disabled armed
        wr(6'h0C, 8'h85);
        wr(6'h10, 8'h86);
        wr(6'h14, 8'h87);
        // R11 latency of a rising pad edge on pin 0
        @(posedge clk); #2; addr = 6'h1C; pad_in[0] = 1'b1; pad_in[7] = 1'b1;
        @(negedge clk); @(negedge clk);
        @(negedge clk); check(rdata[0] == 1'b0, "R11", 32'(rdata), 32'h0);
        @(negedge clk); check(rdata[0] == 1'b1, "R11", 32'(rdata), 32'h1);
        check(event_o == 1'b1, "R11", 32'(event_o), 32'h1);
        check(rdata[7] == 1'b0, "R8", 32'(rdata), 32'h0);
        // R7 masking keeps the flag
        wr(6'h14, 8'h00);
        rd_expect(6'h1C, 8'h01, "R7");
        check(event_o == 1'b0, "R7", 32'(event_o), 32'h0);
        wr(6'h14, 8'h07);
        // R5 both edges on pin 2, falling on pin 1
        @(posedge clk); #2; pad_in[2] = 1'b1;
        repeat (4) @(posedge clk);
        #2; pad_in[2] = 1'b0; pad_in[1] = 1'b1;
        repeat (4) @(posedge clk);
        #2; pad_in[1] = 1'b0;
        repeat (4) @(posedge clk);
        rd_expect(6'h1C, 8'h07, "R5");
        // R6 write-one-to-clear pin 0 only
        wr(6'h1C, 8'h01);
        rd_expect(6'h1C, 8'h06, "R6");
        // mixed traffic, compared every clock against the model
        for (int c = 0; c < 4000; c++) begin
            @(posedge clk); #2;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            pad_in = lfsr[NP-1:0] ^ lfsr[31:18];
            addr   = lfsr[29:24];
            wdata  = lfsr[23:16];
            wr_en  = (lfsr[7:5] == 3'b101);
        end
        @(posedge clk); #2; wr_en = 1'b0;
        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule